// File: doc/BRIEF.md
# Thread Family Lifecycle Controller

This block manages the life of one family of hardware threads on a core. A create command loads a family tag, a first iteration index, an iteration count and an index step. The block then offers one spawn request per cycle on a ready/valid stream, and each spawn carries the next iteration index and the family tag. Every accepted spawn adds one to an in-flight count, and every completion report that carries the family tag removes one.

Three control commands act on the running family. Squeeze stops creation but lets the threads already spawned finish. Kill stops creation and terminates every thread. Break, sent by one thread of the family, stops creation and terminates every thread except that one. A sync request for the family is answered only once creation has ended and no thread is still outstanding.

Only one family is held at a time. After a squeeze, the next index that was not issued and the number of iterations left stay visible, so creation can be resumed later with a fresh create.

Top module: `thread_family_ctrl`

## Requirements
- R1: After reset, spawn_valid, term_valid and fam_done are 0, and sync_ready stays 0 for any sync request.
- R2: A create with count N>0 yields exactly N accepted spawns, with indices start, start+step, start+2*step and so on (modulo 2^IDX_W), all tagged with the create tag. While spawn_valid is 1 and spawn_ready is 0, spawn_idx holds its value.
- R3: A create with count 0 sets fam_done at the next clock edge and never raises spawn_valid.
- R4: fam_done rises only when creation has ended and every accepted spawn has been matched by a completion report with the family tag. It rises at the edge that samples the last such report.
- R5: sync_ready is 1 only when sync_valid is 1, fam_done is 1 and sync_tag equals the family tag. Otherwise it stays 0.
- R6: Squeeze (ctl_op=2) with the family tag while spawning clears spawn_valid at the next edge. Threads already spawned still count toward completion. resume_idx shows the next index that was not issued, and resume_left shows the iterations that remain.
- R7: Kill (ctl_op=1) with the family tag while the family is active gives a one-cycle term_valid with term_spare_en=0 and term_tag set to the family tag. fam_done rises at the same edge. Completion reports after that have no effect.
- R8: Break (ctl_op=0) with the family tag while active gives a one-cycle term_valid with term_spare_en=1 and term_spare_idx equal to ctl_src. Creation stops and fam_done rises at the same edge.
- R9: A control command with a tag other than the family tag is ignored, and so is any control command while idle or done. Code 3 is reserved and ignored.
- R10: A create that arrives while a family is active is ignored. If create and kill arrive in the same cycle while active, the kill is performed and the create is dropped.
- R11: A create accepted while done starts a new family: fam_done clears and spawning restarts with the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| create_valid | input | 1 | Create command strobe |
| create_tag | input | TAG_W | Tag of the new family |
| create_start | input | IDX_W | First iteration index |
| create_count | input | CNT_W | Number of iterations |
| create_step | input | IDX_W | Index increment |
| ctl_valid | input | 1 | Control command strobe |
| ctl_op | input | 2 | 0 break, 1 kill, 2 squeeze, 3 reserved |
| ctl_tag | input | TAG_W | Family that the control command names |
| ctl_src | input | IDX_W | Index of the breaking thread |
| cmpl_valid | input | 1 | Thread completion report |
| cmpl_tag | input | TAG_W | Family of the completed thread |
| sync_valid | input | 1 | Sync request |
| sync_tag | input | TAG_W | Family to wait for |
| sync_ready | output | 1 | Sync request released |
| spawn_valid | output | 1 | Spawn request offered |
| spawn_ready | input | 1 | Spawn request taken |
| spawn_idx | output | IDX_W | Iteration index of the spawn |
| spawn_tag | output | TAG_W | Current family tag |
| term_valid | output | 1 | Terminate strobe |
| term_tag | output | TAG_W | Family to terminate |
| term_spare_en | output | 1 | One thread is spared (break) |
| term_spare_idx | output | IDX_W | Index of the spared thread |
| fam_done | output | 1 | Family finished |
| resume_idx | output | IDX_W | Next index not yet issued |
| resume_left | output | CNT_W | Iterations not yet issued |

## Verification
Spawning is tried with an uninterrupted stream, with a stalled stream that must hold its index, and with a count of zero. Together these separate a wrong step, a lost or repeated index and a wrong hold during a stall. The squeeze, kill and break runs each stop creation part way through. They show whether the block drains or terminates, which thread a break spares, and whether the resume point is right. Commands with a wrong tag, a create sent together with a kill, and commands sent after the family is done all test that ignored inputs leave the ports unchanged.

// File: rtl/fam_pkg.sv
package fam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPAWN = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } fam_state_t;

  localparam logic [1:0] OP_BREAK   = 2'd0;
  localparam logic [1:0] OP_KILL    = 2'd1;
  localparam logic [1:0] OP_SQUEEZE = 2'd2;
endpackage

// File: rtl/fam_seq.sv
module fam_seq #(
  parameter int IDX_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] ld_start,
  input  logic [CNT_W-1:0] ld_count,
  input  logic [IDX_W-1:0] ld_step,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic [CNT_W-1:0] left,
  output logic             last
);
  logic [IDX_W-1:0] stride;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      left   <= '0;
      stride <= '0;
    end else if (load) begin
      idx    <= ld_start;
      left   <= ld_count;
      stride <= ld_step;
    end else if (adv && left != '0) begin
      idx  <= idx + stride;
      left <= left - CNT_W'(1);
    end
  end

  assign last = (left == CNT_W'(1));

  // R2: every issued iteration reduces the remaining count by exactly one
  a_r2_left_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && left != '0) |=> (left == $past(left) - CNT_W'(1)));
endmodule

// File: rtl/fam_occ.sv
module fam_occ #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt
);
  always_comb begin
    nxt = cnt;
    if (inc) nxt = nxt + CNT_W'(1);
    if (dec && (cnt != '0 || inc)) nxt = nxt - CNT_W'(1);
    if (clr) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end

  // R4: a report with nothing outstanding cannot drive the count below zero
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !inc) |=> (cnt == '0));
endmodule

// File: rtl/thread_family_ctrl.sv
module thread_family_ctrl
  import fam_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int CNT_W = 8,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             create_valid,
  input  logic [TAG_W-1:0] create_tag,
  input  logic [IDX_W-1:0] create_start,
  input  logic [CNT_W-1:0] create_count,
  input  logic [IDX_W-1:0] create_step,
  input  logic             ctl_valid,
  input  logic [1:0]       ctl_op,
  input  logic [TAG_W-1:0] ctl_tag,
  input  logic [IDX_W-1:0] ctl_src,
  input  logic             cmpl_valid,
  input  logic [TAG_W-1:0] cmpl_tag,
  input  logic             sync_valid,
  input  logic [TAG_W-1:0] sync_tag,
  output logic             sync_ready,
  output logic             spawn_valid,
  input  logic             spawn_ready,
  output logic [IDX_W-1:0] spawn_idx,
  output logic [TAG_W-1:0] spawn_tag,
  output logic             term_valid,
  output logic [TAG_W-1:0] term_tag,
  output logic             term_spare_en,
  output logic [IDX_W-1:0] term_spare_idx,
  output logic             fam_done,
  output logic [IDX_W-1:0] resume_idx,
  output logic [CNT_W-1:0] resume_left
);
  fam_state_t       st;
  logic [TAG_W-1:0] fam_tag;
  logic             active, ctl_hit, do_kill, do_brk, do_sqz, stop_all;
  logic             create_go, acc, seq_last, occ_clr, occ_dec;
  logic [IDX_W-1:0] seq_idx;
  logic [CNT_W-1:0] seq_left, occ_cnt, occ_nxt;

  assign active    = (st == ST_SPAWN) || (st == ST_DRAIN);
  assign ctl_hit   = ctl_valid && active && (ctl_tag == fam_tag);
  assign do_kill   = ctl_hit && (ctl_op == OP_KILL);
  assign do_brk    = ctl_hit && (ctl_op == OP_BREAK);
  assign do_sqz    = ctl_hit && (ctl_op == OP_SQUEEZE) && (st == ST_SPAWN);
  assign stop_all  = do_kill || do_brk;
  assign create_go = create_valid && !active && !stop_all;
  assign acc       = spawn_valid && spawn_ready;
  assign occ_clr   = stop_all || create_go;
  assign occ_dec   = cmpl_valid && active && (cmpl_tag == fam_tag);

  fam_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .load(create_go),
    .ld_start(create_start), .ld_count(create_count), .ld_step(create_step),
    .adv(acc), .idx(seq_idx), .left(seq_left), .last(seq_last)
  );

  fam_occ #(.CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst(rst), .clr(occ_clr), .inc(acc), .dec(occ_dec),
    .cnt(occ_cnt), .nxt(occ_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      fam_tag        <= '0;
      term_valid     <= 1'b0;
      term_tag       <= '0;
      term_spare_en  <= 1'b0;
      term_spare_idx <= '0;
    end else begin
      term_valid <= stop_all;
      if (stop_all) begin
        term_tag       <= fam_tag;
        term_spare_en  <= do_brk;
        term_spare_idx <= ctl_src;
        st             <= ST_DONE;
      end else if (create_go) begin
        fam_tag <= create_tag;
        st      <= (create_count == '0) ? ST_DONE : ST_SPAWN;
      end else if (st == ST_SPAWN) begin
        if (acc && seq_last)
          st <= ST_DRAIN;
        else if (do_sqz)
          st <= (occ_nxt == '0) ? ST_DONE : ST_DRAIN;
      end else if (st == ST_DRAIN) begin
        if (occ_nxt == '0) st <= ST_DONE;
      end
    end
  end

  assign spawn_valid = (st == ST_SPAWN);
  assign spawn_idx   = seq_idx;
  assign spawn_tag   = fam_tag;
  assign fam_done    = (st == ST_DONE);
  assign resume_idx  = seq_idx;
  assign resume_left = seq_left;
  assign sync_ready  = sync_valid && fam_done && (sync_tag == fam_tag);

  // R2: an offered spawn that is not taken keeps its index
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (spawn_valid && !spawn_ready && !ctl_valid) |=> (spawn_valid && $stable(spawn_idx)));
  // R4: the family is done only with nothing outstanding
  a_r4_done_empty: assert property (@(posedge clk) disable iff (rst)
    fam_done |-> (occ_cnt == '0));
  // R5: sync is released only for a finished family
  a_r5_sync_done: assert property (@(posedge clk) disable iff (rst)
    sync_ready |-> fam_done);
  // R6: a squeeze that names the family ends spawning
  a_r6_squeeze_stop: assert property (@(posedge clk) disable iff (rst)
    (spawn_valid && ctl_valid && ctl_op == OP_SQUEEZE && ctl_tag == spawn_tag) |=> !spawn_valid);
  // R7: the terminate strobe lasts one cycle
  a_r7_term_pulse: assert property (@(posedge clk) disable iff (rst)
    term_valid |=> !term_valid);
  // R7: terminate and done rise together
  a_r7_term_done: assert property (@(posedge clk) disable iff (rst)
    term_valid |-> fam_done);
endmodule

// File: tb/test_thread_family_ctrl.sv
module test_thread_family_ctrl;
  localparam int IDX_W = 16;
  localparam int CNT_W = 8;
  localparam int TAG_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic create_valid = 1'b0;
  logic [TAG_W-1:0] create_tag = '0;
  logic [IDX_W-1:0] create_start = '0;
  logic [CNT_W-1:0] create_count = '0;
  logic [IDX_W-1:0] create_step = '0;
  logic ctl_valid = 1'b0;
  logic [1:0] ctl_op = '0;
  logic [TAG_W-1:0] ctl_tag = '0;
  logic [IDX_W-1:0] ctl_src = '0;
  logic cmpl_valid = 1'b0;
  logic [TAG_W-1:0] cmpl_tag = '0;
  logic sync_valid = 1'b0;
  logic [TAG_W-1:0] sync_tag = '0;
  logic spawn_ready = 1'b0;
  logic sync_ready, spawn_valid, term_valid, term_spare_en, fam_done;
  logic [IDX_W-1:0] spawn_idx, term_spare_idx, resume_idx;
  logic [TAG_W-1:0] spawn_tag, term_tag;
  logic [CNT_W-1:0] resume_left;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  thread_family_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) i_thread_family_ctrl (
    .clk(clk), .rst(rst),
    .create_valid(create_valid), .create_tag(create_tag), .create_start(create_start),
    .create_count(create_count), .create_step(create_step),
    .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_tag(ctl_tag), .ctl_src(ctl_src),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
    .sync_valid(sync_valid), .sync_tag(sync_tag), .sync_ready(sync_ready),
    .spawn_valid(spawn_valid), .spawn_ready(spawn_ready), .spawn_idx(spawn_idx),
    .spawn_tag(spawn_tag), .term_valid(term_valid), .term_tag(term_tag),
    .term_spare_en(term_spare_en), .term_spare_idx(term_spare_idx),
    .fam_done(fam_done), .resume_idx(resume_idx), .resume_left(resume_left)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic create(input int tag, input int start, input int cnt, input int stp);
    create_valid = 1'b1; create_tag = TAG_W'(tag); create_start = IDX_W'(start);
    create_count = CNT_W'(cnt); create_step = IDX_W'(stp);
    step();
    create_valid = 1'b0;
  endtask

  task automatic ctl(input int op, input int tag, input int src);
    ctl_valid = 1'b1; ctl_op = 2'(op); ctl_tag = TAG_W'(tag); ctl_src = IDX_W'(src);
    step();
    ctl_valid = 1'b0;
  endtask

  task automatic complete(input int tag);
    cmpl_valid = 1'b1; cmpl_tag = TAG_W'(tag);
    step();
    cmpl_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 spawn_valid", 32'(spawn_valid), 0);
    chk("R1 term_valid", 32'(term_valid), 0);
    chk("R1 fam_done", 32'(fam_done), 0);
    sync_valid = 1'b1; sync_tag = '0; #1;
    chk("R1 sync_ready", 32'(sync_ready), 0);
    sync_valid = 1'b0;
  endtask

  task automatic t_stream();
    create(2, 5, 4, 3);
    chk("R2 tag", 32'(spawn_tag), 2);
    for (int k = 0; k < 4; k++) begin
      chk("R2 valid", 32'(spawn_valid), 1);
      chk("R2 index", 32'(spawn_idx), 32'(5 + 3 * k));
      if (k == 2) begin
        spawn_ready = 1'b0; step();
        chk("R2 hold", 32'(spawn_idx), 11);
      end
      spawn_ready = 1'b1; step();
      spawn_ready = 1'b0;
    end
    chk("R2 count ends", 32'(spawn_valid), 0);
    sync_valid = 1'b1; sync_tag = 4'd2; #1;
    chk("R5 sync before done", 32'(sync_ready), 0);
    sync_valid = 1'b0;
    complete(9);
    chk("R4 foreign report", 32'(fam_done), 0);
    for (int k = 0; k < 3; k++) complete(2);
    chk("R4 one outstanding", 32'(fam_done), 0);
    complete(2);
    chk("R4 last report", 32'(fam_done), 1);
    sync_valid = 1'b1; sync_tag = 4'd2; #1;
    chk("R5 sync match", 32'(sync_ready), 1);
    sync_tag = 4'd4; #1;
    chk("R5 sync other tag", 32'(sync_ready), 0);
    sync_valid = 1'b0;
  endtask

  task automatic t_zero();
    create(6, 0, 0, 1);
    chk("R3 done", 32'(fam_done), 1);
    chk("R3 no spawn", 32'(spawn_valid), 0);
    chk("R11 new tag", 32'(spawn_tag), 6);
  endtask

  task automatic t_squeeze();
    create(1, 100, 10, 2);
    chk("R11 done cleared", 32'(fam_done), 0);
    spawn_ready = 1'b1;
    for (int k = 0; k < 3; k++) step();
    spawn_ready = 1'b0;
    ctl(2, 8, 0);
    chk("R9 wrong tag squeeze", 32'(spawn_valid), 1);
    chk("R9 index kept", 32'(spawn_idx), 106);
    ctl(3, 1, 0);
    chk("R9 reserved op", 32'(spawn_valid), 1);
    ctl(2, 1, 0);
    chk("R6 spawn stops", 32'(spawn_valid), 0);
    chk("R6 resume index", 32'(resume_idx), 106);
    chk("R6 resume left", 32'(resume_left), 7);
    chk("R6 not done", 32'(fam_done), 0);
    complete(1); complete(1);
    chk("R6 draining", 32'(fam_done), 0);
    complete(1);
    chk("R6 drained", 32'(fam_done), 1);
  endtask

  task automatic t_kill();
    create(3, 0, 5, 1);
    spawn_ready = 1'b1; step(); step(); spawn_ready = 1'b0;
    create(7, 50, 3, 1);
    chk("R10 create ignored idx", 32'(spawn_idx), 2);
    chk("R10 create ignored tag", 32'(spawn_tag), 3);
    create_valid = 1'b1; create_tag = 4'd7; create_count = 8'd3;
    ctl(1, 3, 0);
    create_valid = 1'b0;
    chk("R10 kill wins", 32'(fam_done), 1);
    chk("R7 term", 32'(term_valid), 1);
    chk("R7 no spare", 32'(term_spare_en), 0);
    chk("R7 term tag", 32'(term_tag), 3);
    chk("R7 spawn off", 32'(spawn_valid), 0);
    complete(3);
    chk("R7 pulse", 32'(term_valid), 0);
    chk("R7 report no effect", 32'(fam_done), 1);
    ctl(1, 3, 0);
    chk("R9 kill while done", 32'(term_valid), 0);
    chk("R9 still done", 32'(fam_done), 1);
  endtask

  task automatic t_break();
    create(5, 20, 6, 4);
    spawn_ready = 1'b1; step(); spawn_ready = 1'b0;
    chk("R8 second index", 32'(spawn_idx), 24);
    ctl(0, 5, 20);
    chk("R8 term", 32'(term_valid), 1);
    chk("R8 spare", 32'(term_spare_en), 1);
    chk("R8 spare idx", 32'(term_spare_idx), 20);
    chk("R8 done", 32'(fam_done), 1);
    chk("R8 spawn off", 32'(spawn_valid), 0);
  endtask

  task automatic t_restart();
    create(9, 1, 1, 1);
    chk("R11 fresh family", 32'(fam_done), 0);
    chk("R11 spawning", 32'(spawn_valid), 1);
    chk("R11 tag", 32'(spawn_tag), 9);
    spawn_ready = 1'b1; step(); spawn_ready = 1'b0;
    complete(9);
    chk("R11 finishes", 32'(fam_done), 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    step();
    t_reset();
    t_stream();
    t_zero();
    t_squeeze();
    t_kill();
    t_break();
    t_restart();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule